// File: doc/BRIEF.md
# Iota Round-Constant Sequencer

This block supplies the per-round constant that the iota step of a Keccak-f permutation XORs into lane (0,0). It does not store the 24 constants. An 8-bit linear feedback shift register is stepped once per clock, and each step yields one constant bit. Seven steps make up one round's constant. The seven bits land at positions 0, 1, 3, 7, 15, 31 and 63, and all other bits are zero. The lane width is a parameter, so narrower permutations see only the low bits of the 64-bit constant.

A controller pulses `restart_i` to begin a new permutation at round 0. After that, it pulses `adv_i` each time the round datapath has used the current constant. The shift register is never reseeded between rounds, because the bit index runs on without a break from one round into the next. `const_vld_o` is low while a constant is being assembled and high while `const_o` holds a finished constant.

Top module: `iota_const_gen`

## Requirements
- R1: After reset, `const_vld_o` is 0 and `const_o` is all zeros.
- R2: `restart_i` sampled high at a clock edge drops `const_vld_o` after that edge. `const_vld_o` rises again after exactly seven further edges, and `const_o` then holds the round-0 constant (value 1).
- R3: The 8-bit register is seeded with only bit 0 set. Each step moves every bit one place toward the MSB and fills bit 0 with zero. When the bit that left bit 7 is 1, bits 0, 4, 5 and 6 are inverted. The constant bit at position 2^j-1 (j = 0..6) of round r equals bit 0 of the register before step number 7r+j counted from the seed. Every other constant bit is 0.
- R4: When `adv_i` is sampled high while valid, on a round below the last, `const_vld_o` drops after that edge. The next round's constant is valid seven edges later, with the register continuing from where it stopped.
- R5: While `const_vld_o` stays high, `const_o` does not change.
- R6: With `LANE_W` below 64, `const_o` equals the low `LANE_W` bits of the 64-bit constant of the same round.
- R7: When `restart_i` and `adv_i` are high in the same cycle, the restart wins and round 0 is produced.
- R8: `adv_i` has no effect while `const_vld_o` is low, either before any restart or during assembly.
- R9: Once the constant for round `ROUND_LIMIT-1` is valid, `adv_i` is ignored: the valid flag and the constant stay as they are.
- R10: `restart_i` during assembly abandons it and reseeds, so the sequence starts again from round 0.
- R11: For a 64-bit lane, round 0 is 0x0000000000000001, round 1 is 0x0000000000008082, round 2 is 0x800000000000808A and round 23 is 0x8000000080008008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Start again at round 0 with a fresh seed |
| adv_i | input | 1 | Current constant consumed; build the next round |
| const_o | output | LANE_W | Round constant, low LANE_W bits |
| const_vld_o | output | 1 | const_o holds a complete constant |

## Verification
Restart and advance can fall in the same cycle. They can do so while a constant is held, on the last round, and during assembly. The bench drives both strobes on one edge at round 0 and at round 23. It judges the result by whether the constant that follows is round 0 rather than round 1, or rather than nothing. A behavioural model in the bench runs the shift register as an integer, following the textbook polynomial algorithm. It tracks the expected valid flag and constant, and it is compared on every clock against 64-, 32- and 8-bit instances.

// File: rtl/iota_const_pkg.sv
`timescale 1ns/1ps
package iota_const_pkg;

  localparam int unsigned SR_W            = 8;
  localparam logic [SR_W-1:0] SR_SEED     = 8'h01;
  localparam logic [SR_W-1:0] SR_TAPS     = 8'h71;  // bits 0,4,5,6
  localparam int unsigned STEPS_PER_ROUND = 7;
  localparam int unsigned SLOT_W          = $clog2(STEPS_PER_ROUND);
  localparam int unsigned ABS_MAX_ROUNDS  = 24;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FILL,
    SEQ_HOLD
  } seq_e;

  // One step: shift toward the MSB, fold the outgoing bit into the taps.
  function automatic logic [SR_W-1:0] sr_advance(input logic [SR_W-1:0] cur);
    logic [SR_W-1:0] shifted;
    shifted = {cur[SR_W-2:0], 1'b0};
    return cur[SR_W-1] ? (shifted ^ SR_TAPS) : shifted;
  endfunction

  // Step index j whose bit lands at position p (p = 2^j - 1), else -1.
  function automatic int slot_of(input int p);
    for (int j = 0; j < int'(STEPS_PER_ROUND); j++) begin
      if ((1 << j) - 1 == p) return j;
    end
    return -1;
  endfunction

endpackage

// File: rtl/iota_sr.sv
`timescale 1ns/1ps
module iota_sr
  import iota_const_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic seed_i,
  input  logic step_i,
  output logic bit_o
);

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= SR_SEED;
    else if (seed_i) sr_q <= SR_SEED;
    else if (step_i) sr_q <= sr_advance(sr_q);
  end

  assign bit_o = sr_q[0];

  // R3: a maximal-length register never falls into the all-zero state
  p_reg_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);

  // R3: seeding leaves only bit 0 set
  p_seed_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_i |=> (sr_q == SR_SEED));

  // R3: the register is frozen when neither seeding nor stepping
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && !step_i) |=> $stable(sr_q));

endmodule

// File: rtl/iota_seq.sv
`timescale 1ns/1ps
module iota_seq
  import iota_const_pkg::*;
#(
  parameter int unsigned ROUND_LIMIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic              seed_o,
  output logic              step_o,
  output logic              clear_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);

  localparam int unsigned RND_W = (ROUND_LIMIT > 1) ? $clog2(ROUND_LIMIT) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(STEPS_PER_ROUND - 1);
  localparam logic [RND_W-1:0]  LAST_ROUND = RND_W'(ROUND_LIMIT - 1);

  seq_e              state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [RND_W-1:0]  round_q;
  logic              last_round;
  logic              advance_go;

  assign last_round = (round_q == LAST_ROUND);
  assign advance_go = adv_i && !restart_i && (state_q == SEQ_HOLD) && !last_round;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      slot_q  <= '0;
      round_q <= '0;
    end else if (restart_i) begin
      state_q <= SEQ_FILL;
      slot_q  <= '0;
      round_q <= '0;
    end else if (advance_go) begin
      state_q <= SEQ_FILL;
      slot_q  <= '0;
      round_q <= round_q + RND_W'(1);
    end else if (state_q == SEQ_FILL) begin
      if (slot_q == LAST_SLOT) begin
        state_q <= SEQ_HOLD;
        slot_q  <= '0;
      end else begin
        slot_q  <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign seed_o  = restart_i;
  assign step_o  = (state_q == SEQ_FILL) && !restart_i;
  assign clear_o = restart_i || advance_go;
  assign slot_o  = slot_q;
  assign valid_o = (state_q == SEQ_HOLD);

  // R2: a restart always invalidates the output on the next cycle
  p_restart_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !valid_o);

  // R2: valid only rises after the final of the seven steps
  p_fill_seven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> ($past(slot_q) == LAST_SLOT));

  // R4: advancing below the last round drops valid
  p_adv_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && adv_i && !restart_i && !last_round) |=> !valid_o);

  // R7: restart beats advance on the same edge
  p_restart_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && adv_i) |=> (round_q == '0));

  // R8: an advance while idle leaves the sequencer idle
  p_idle_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !restart_i) |=> (state_q == SEQ_IDLE));

  // R9: on the last round the held constant stays valid
  p_last_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_round && !restart_i) |=> valid_o);

endmodule

// File: rtl/iota_acc.sv
`timescale 1ns/1ps
module iota_acc
  import iota_const_pkg::*;
#(
  parameter int unsigned LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              bit_i,
  input  logic              valid_i,
  output logic [LANE_W-1:0] word_o
);

  logic [LANE_W-1:0] acc_q;
  logic [LANE_W-1:0] acc_d;
  logic [LANE_W-1:0] hit;

  for (genvar p = 0; p < int'(LANE_W); p++) begin : g_pos
    localparam int SLOT = slot_of(p);
    if (SLOT >= 0) begin : g_slot
      assign hit[p] = step_i && (slot_i == SLOT_W'(SLOT));
    end else begin : g_zero
      assign hit[p] = 1'b0;
    end
  end

  always_comb begin
    if (clear_i) acc_d = '0;
    else         acc_d = (acc_q & ~hit) | (hit & {LANE_W{bit_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign word_o = acc_q;

  // R4: a new round starts from an empty constant
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (word_o == '0));

  // R5: the held constant does not move while valid persists
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(valid_i)) |-> $stable(word_o));

endmodule

// File: rtl/iota_const_gen.sv
`timescale 1ns/1ps
module iota_const_gen
  import iota_const_pkg::*;
#(
  parameter int unsigned LANE_W      = 64,
  parameter int unsigned ROUND_LIMIT = ABS_MAX_ROUNDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              adv_i,
  output logic [LANE_W-1:0] const_o,
  output logic              const_vld_o
);

  logic              seed_w;
  logic              step_w;
  logic              clear_w;
  logic [SLOT_W-1:0] slot_w;
  logic              sr_bit_w;
  logic              valid_w;

  iota_seq #(
    .ROUND_LIMIT(ROUND_LIMIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart_i),
    .adv_i    (adv_i),
    .seed_o   (seed_w),
    .step_o   (step_w),
    .clear_o  (clear_w),
    .slot_o   (slot_w),
    .valid_o  (valid_w)
  );

  iota_sr u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .seed_i(seed_w),
    .step_i(step_w),
    .bit_o (sr_bit_w)
  );

  iota_acc #(
    .LANE_W(LANE_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(clear_w),
    .step_i (step_w),
    .slot_i (slot_w),
    .bit_i  (sr_bit_w),
    .valid_i(valid_w),
    .word_o (const_o)
  );

  assign const_vld_o = valid_w;

  // R3: the register steps only while a constant is being assembled
  p_step_only_filling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> !const_vld_o);

endmodule

// File: tb/iota_const_gen_tb.sv
`timescale 1ns/1ps
module iota_const_gen_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic restart;
  logic nxt;
  always #2.5 clk = ~clk;

  logic [63:0] rc64;
  logic [31:0] rc32;
  logic [7:0]  rc8;
  logic        v64, v32, v8;

  iota_const_gen #(.LANE_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .adv_i(nxt),
    .const_o(rc64), .const_vld_o(v64));
  iota_const_gen #(.LANE_W(32)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .adv_i(nxt),
    .const_o(rc32), .const_vld_o(v32));
  iota_const_gen #(.LANE_W(8)) u_dut_w8 (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .adv_i(nxt),
    .const_o(rc8), .const_vld_o(v8));

  int    vectors = 0;
  int    misses  = 0;
  string req     = "R1";

  // Textbook polynomial form: integer register, bit 8 folded back.
  function automatic bit rc_bit(int t);
    int r = 1;
    for (int i = 0; i < t % 255; i++) begin
      r = r << 1;
      if ((r & 256) != 0) r = (r ^ 256) ^ 'h71;
    end
    return bit'(r & 1);
  endfunction

  function automatic logic [63:0] rc_const(int rnd);
    logic [63:0] c = '0;
    for (int j = 0; j < 7; j++) c[(1 << j) - 1] = rc_bit(j + 7 * rnd);
    return c;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Cycle model: m_cnt = -1 idle, 0..6 steps done, 7 holding.
  int m_cnt;
  int m_round;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   <= -1;
      m_round <= 0;
    end else if (restart) begin
      m_cnt   <= 0;
      m_round <= 0;
    end else if (nxt && m_cnt == 7 && m_round < 23) begin
      m_cnt   <= 0;
      m_round <= m_round + 1;
    end else if (m_cnt >= 0 && m_cnt < 7) begin
      m_cnt   <= m_cnt + 1;
    end
  end

  // Per-clock comparison against the model on all three widths (R3, R5, R6).
  always @(negedge clk) begin
    if (rst_n) begin
      logic [63:0] e;
      logic        ev;
      ev = (m_cnt == 7);
      e  = rc_const(m_round);
      chk({req, " valid w64"}, {63'd0, v64}, {63'd0, ev});
      chk({req, " valid w32"}, {63'd0, v32}, {63'd0, ev});
      chk({req, " valid w8"},  {63'd0, v8},  {63'd0, ev});
      if (ev) begin
        chk({req, " R3 const w64"}, rc64, e);
        chk({req, " R6 const w32"}, {32'd0, rc32}, {32'd0, e[31:0]});
        chk({req, " R6 const w8"},  {56'd0, rc8},  {56'd0, e[7:0]});
      end
    end
  end

  task automatic wait_valid();
    int guard = 0;
    while (!v64 && guard < 20) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic pulse(logic do_restart, logic do_adv);
    restart = do_restart;
    nxt     = do_adv;
    @(negedge clk);
    restart = 1'b0;
    nxt     = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; nxt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset const", rc64, 64'd0);
    chk("R1 reset valid", {63'd0, v64}, 64'd0);
    rst_n = 1'b1;

    req = "R8";
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 idle advance", {63'd0, v64}, 64'd0);

    req = "R2";
    pulse(1'b1, 1'b0);
    chk("R2 drop", {63'd0, v64}, 64'd0);
    repeat (2) @(negedge clk);
    req = "R8";
    pulse(1'b0, 1'b1);
    req = "R2";
    wait_valid();
    chk("R2 round0", rc64, 64'h1);
    chk("R11 round0", rc64, 64'h0000000000000001);

    for (int r = 1; r < 24; r++) begin
      req = "R4";
      repeat (r % 3) @(negedge clk);
      pulse(1'b0, 1'b1);
      repeat (6) @(negedge clk);
      chk("R4 not early", {63'd0, v64}, 64'd0);
      @(negedge clk);
      chk("R4 valid", {63'd0, v64}, 64'd1);
      chk("R6 w8 trunc", {56'd0, rc8}, {56'd0, rc64[7:0]});
      chk("R6 w32 trunc", {32'd0, rc32}, {32'd0, rc64[31:0]});
      if (r == 1)  chk("R11 round1", rc64, 64'h0000000000008082);
      if (r == 2)  chk("R11 round2", rc64, 64'h800000000000808A);
      if (r == 23) chk("R11 round23", rc64, 64'h8000000080008008);
    end

    req = "R9";
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 still valid", {63'd0, v64}, 64'd1);
    chk("R9 held", rc64, 64'h8000000080008008);

    req = "R7";
    pulse(1'b1, 1'b1);
    wait_valid();
    chk("R7 restart at last", rc64, 64'h1);
    pulse(1'b1, 1'b1);
    wait_valid();
    chk("R7 restart over advance", rc64, 64'h1);

    req = "R10";
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_valid();
    chk("R10 reseeded round0", rc64, 64'h1);
    pulse(1'b0, 1'b1);
    wait_valid();
    chk("R10 then round1", rc64, 64'h0000000000008082);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule